// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers interrupt requests into one status word and drives a single interrupt line towards a host processor. Four bank summary lines come from general-purpose I/O banks that do their own per-pin masking; six further peripheral request lines are captured by the aggregator itself. Bank lines appear in the low status bits exactly as they arrive. Peripheral requests are held in sticky pending flags until software clears them by writing ones.

Software reaches the block through a small synchronous register port with three words: status (read, write-one-to-clear), mask (a global enable in the lowest bit and one enable per peripheral source above it) and run control (one bit that starts the controller). While the run bit is clear the controller stands frozen: no request is captured, no mask or clear write lands, and the interrupt line keeps its level. Only a write to the run word still takes effect. The host treats the interrupt line as rising-edge triggered, so the line always drops and stays low for a while before it can rise again.

The output is made by a three-state machine. IDLE holds the line low. It moves to ACTIVE when the global enable is set and any bank line or enabled pending flag is present. ACTIVE holds the line high and stays there while that condition lasts. When the condition goes away, ACTIVE moves to REARM. REARM holds the line low for one cycle and always returns to IDLE. No state changes while the controller is frozen.

Top module: `irq_aggregator`

## Requirements
- R1: During and straight after reset the interrupt line is low, and the status, mask and run words all read zero.
- R2: A read of address 0 returns the four bank summary inputs in bits 0 to 3, bank 0 in bit 0, as they are in the same cycle.
- R3: While running, a high peripheral input k sets the pending flag shown in status bit 4+k at the next clock edge; the flag stays set after the input drops.
- R4: A write to address 0 while running clears each pending flag whose bit (4+k) is written as one, unless its input is high in that cycle; bits written as zero and bits 0 to 3 change nothing.
- R5: Address 1 holds the mask: bit 0 is the global enable and bit 1+k enables peripheral source k; bits above 6 read zero, and address 3 reads all zero.
- R6: From IDLE, the interrupt line rises one clock after a cycle in which the global enable is set and some bank input or enabled pending flag is high.
- R7: The line stays high while that condition holds, and falls one clock after a cycle without it; after falling it stays low for at least two cycles.
- R8: Address 2 bit 0 is the run bit, written in any state; while it reads zero, pending flags, mask and interrupt line do not change.
- R9: A pending flag whose enable bit is clear still shows in the status word but does not raise the interrupt line.
- R10: With the global enable clear the interrupt line is low, or goes low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sum_i | input | 4 | Summary request lines from the I/O banks |
| src_i | input | 6 | Peripheral request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 status, 1 mask, 2 run) |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt line to the host, edge-signalled |

## Verification
Directed sequences drive a lone bank line, a peripheral source with its enable clear and then set, a write-one clear that races a still-high source, a global disable while the line is high, and a freeze with writes and requests arriving during it. Each one separates a different cause of the line rising or falling. A long random phase then mixes sparse bank and source pulses with writes to every address, including frequent run-bit drops. This exposes wrong freeze scope, missing set-over-clear priority and a missing low gap between edges, because a cycle-accurate bench model predicts both the line and every read word in every cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RUN    = 2'd2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_REARM  = 2'd2
    } agg_state_e;

endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int N_BANKS  = 4,
    parameter int N_PERIPH = 6,
    parameter int DATA_W   = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic                  run_o,
    output logic [N_PERIPH:0]     mask_o,
    output logic [N_PERIPH-1:0]   clear_o
);
    localparam int STAT_W = N_BANKS + N_PERIPH;
    localparam int MASK_W = N_PERIPH + 1;

    logic              run_q;
    logic [MASK_W-1:0] mask_q;
    logic              wr_run;
    logic              wr_mask;
    logic              wr_status;

    always_comb begin
        wr_run    = wr_en_i && (addr_i == ADDR_RUN);
        wr_mask   = wr_en_i && (addr_i == ADDR_MASK) && run_q;
        wr_status = wr_en_i && (addr_i == ADDR_STATUS) && run_q;
    end

    // run control is the only word that accepts writes while frozen
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 1'b0;
        end else if (wr_run) begin
            run_q <= wr_data_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= wr_data_i[MASK_W-1:0];
        end
    end

    always_comb begin
        clear_o = wr_status ? wr_data_i[STAT_W-1:N_BANKS] : '0;
    end

    assign run_o  = run_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
    parameter int N_PERIPH = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic [N_PERIPH-1:0] src_i,
    input  logic [N_PERIPH-1:0] clear_i,
    output logic [N_PERIPH-1:0] pend_o
);
    for (genvar k = 0; k < N_PERIPH; k++) begin : g_flag
        logic flag_q;

        // a request in the same cycle wins over a clear
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                flag_q <= 1'b0;
            end else if (run_i) begin
                flag_q <= (flag_q & ~clear_i[k]) | src_i[k];
            end
        end

        assign pend_o[k] = flag_q;
    end

endmodule

// File: rtl/irqagg_fsm.sv
module irqagg_fsm
    import irqagg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic cond_i,
    output logic irq_o
);
    agg_state_e state_q;
    agg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = cond_i ? S_ACTIVE : S_IDLE;
            S_ACTIVE: state_d = cond_i ? S_ACTIVE : S_REARM;
            S_REARM:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else if (run_i) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == S_ACTIVE);
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int N_BANKS  = 4,
    parameter int N_PERIPH = 6,
    parameter int DATA_W   = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_BANKS-1:0]  bank_sum_i,
    input  logic [N_PERIPH-1:0] src_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_o
);
    localparam int STAT_W = N_BANKS + N_PERIPH;
    localparam int MASK_W = N_PERIPH + 1;

    logic                run_q;
    logic [MASK_W-1:0]   mask_q;
    logic [N_PERIPH-1:0] clear_w;
    logic [N_PERIPH-1:0] pend_q;
    logic [STAT_W-1:0]   status_w;
    logic                cond_w;

    irqagg_regs #(
        .N_BANKS  (N_BANKS),
        .N_PERIPH (N_PERIPH),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .run_o     (run_q),
        .mask_o    (mask_q),
        .clear_o   (clear_w)
    );

    irqagg_pending #(
        .N_PERIPH (N_PERIPH)
    ) u_pend (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_q),
        .src_i   (src_i),
        .clear_i (clear_w),
        .pend_o  (pend_q)
    );

    always_comb begin
        status_w = {pend_q, bank_sum_i};
        cond_w   = mask_q[0] &&
                   ((|bank_sum_i) || (|(pend_q & mask_q[MASK_W-1:1])));
    end

    irqagg_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_q),
        .cond_i (cond_w),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            ADDR_STATUS: rd_data_o[STAT_W-1:0] = status_w;
            ADDR_MASK:   rd_data_o[MASK_W-1:0] = mask_q;
            ADDR_RUN:    rd_data_o[0]          = run_q;
            default:     rd_data_o             = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int N_BANKS  = 4,
    parameter int N_PERIPH = 6,
    parameter int DATA_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                irq,
    input logic [N_PERIPH:0]   mask,
    input logic [N_PERIPH-1:0] pend,
    input logic [N_BANKS-1:0]  bank,
    input logic [N_PERIPH-1:0] src,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W-1:0]   rd_data
);
    localparam int STAT_W = N_BANKS + N_PERIPH;

    logic cond_chk;
    assign cond_chk = mask[0] && ((|bank) || (|(pend & mask[N_PERIPH:1])));

    p_bank_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_STATUS) |-> (rd_data[N_BANKS-1:0] == bank));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(wr_en && addr == ADDR_STATUS)) |=> ((pend & $past(pend)) == $past(pend)));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && addr == ADDR_STATUS)
        |=> ((pend & $past(wr_data[STAT_W-1:N_BANKS] & ~src)) == '0));

    p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cond_chk));

    p_low_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |=> !irq);

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(irq) && $stable(pend) && $stable(mask)));

    p_glb_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mask[0]) |=> !irq);

endmodule

bind irq_aggregator irqagg_checker #(
    .N_BANKS  (N_BANKS),
    .N_PERIPH (N_PERIPH),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .run     (run_q),
    .irq     (irq_o),
    .mask    (mask_q),
    .pend    (pend_q),
    .bank    (bank_sum_i),
    .src     (src_i),
    .wr_en   (wr_en_i),
    .addr    (addr_i),
    .wr_data (wr_data_i),
    .rd_data (rd_data_o)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank = '0;
    logic [5:0]  src = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wd = '0;
    logic [15:0] rd;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [5:0] m_pend = '0;
    logic [6:0] m_mask = '0;
    logic       m_run = 1'b0;
    int         m_st = 0;   // 0 idle, 1 active, 2 rearm

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bank_sum_i (bank),
        .src_i      (src),
        .wr_en_i    (we),
        .addr_i     (addr),
        .wr_data_i  (wd),
        .rd_data_o  (rd),
        .irq_o      (irq)
    );

    function automatic logic [15:0] exp_rd(input logic [1:0] a, input logic [3:0] bk);
        logic [15:0] v = '0;
        case (a)
            2'd0: v[9:0] = {m_pend, bk};
            2'd1: v[6:0] = m_mask;
            2'd2: v[0]   = m_run;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d,
                        input logic [3:0] bk, input logic [5:0] sr);
        logic       cond;
        logic [5:0] n_pend;
        logic [6:0] n_mask;
        logic       n_run;
        int         n_st;
        @(negedge clk);
        we = w; addr = a; wd = d; bank = bk; src = sr;
        #1;
        check("R6 R7 R9 R10 irq", {15'd0, irq}, {15'd0, (m_st == 1)});
        case (a)
            2'd0: check("R2 R3 R4 status", rd, exp_rd(a, bk));
            2'd1: check("R5 mask", rd, exp_rd(a, bk));
            2'd2: check("R8 run", rd, exp_rd(a, bk));
            default: check("R5 unused", rd, exp_rd(a, bk));
        endcase
        cond   = m_mask[0] && ((|bk) || (|(m_pend & m_mask[6:1])));
        n_pend = m_pend; n_mask = m_mask; n_st = m_st;
        n_run  = (w && a == 2'd2) ? d[0] : m_run;
        if (m_run) begin
            if (w && a == 2'd1) n_mask = d[6:0];
            n_pend = (m_pend & ~((w && a == 2'd0) ? d[9:4] : 6'd0)) | sr;
            case (m_st)
                0: n_st = cond ? 1 : 0;
                1: n_st = cond ? 1 : 2;
                default: n_st = 0;
            endcase
        end
        @(posedge clk);
        m_pend = n_pend; m_mask = n_mask; m_run = n_run; m_st = n_st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 irq", {15'd0, irq}, 16'd0);
        addr = 2'd0; #1 check("R1 status", rd, 16'd0);
        addr = 2'd1; #1 check("R1 mask", rd, 16'd0);
        addr = 2'd2; #1 check("R1 run", rd, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 2'd1, 16'd0, 4'h0, 6'h00);
        // frozen by default: a mask write must not land (R8)
        step(1, 2'd1, 16'h007f, 4'h0, 6'h01);
        step(0, 2'd1, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // start, enable global only
        step(1, 2'd2, 16'h0001, 4'h0, 6'h00);
        step(1, 2'd1, 16'h0001, 4'h0, 6'h00);
        // lone bank line: R2, R6, R7
        step(0, 2'd0, 16'd0, 4'h2, 6'h00);
        step(0, 2'd0, 16'd0, 4'h2, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h8, 6'h00);
        step(0, 2'd0, 16'd0, 4'h8, 6'h00);
        step(0, 2'd0, 16'd0, 4'h8, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // disabled source: R3, R9
        step(0, 2'd0, 16'd0, 4'h0, 6'h04);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // enable source 2 (mask bit 3): R5
        step(1, 2'd1, 16'h0009, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // clear racing a high source, then a clean clear: R4
        step(1, 2'd0, 16'h0040, 4'h0, 6'h04);
        step(1, 2'd0, 16'h000f, 4'h0, 6'h00);
        step(1, 2'd0, 16'h0040, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // global disable while high: R10
        step(0, 2'd0, 16'd0, 4'h1, 6'h00);
        step(0, 2'd0, 16'd0, 4'h1, 6'h00);
        step(1, 2'd1, 16'h007e, 4'h1, 6'h00);
        step(0, 2'd0, 16'd0, 4'h1, 6'h00);
        step(0, 2'd0, 16'd0, 4'h1, 6'h00);
        // freeze while active: R8
        step(1, 2'd1, 16'h007f, 4'h1, 6'h00);
        step(0, 2'd0, 16'd0, 4'h1, 6'h00);
        step(1, 2'd2, 16'h0000, 4'h0, 6'h3f);
        step(1, 2'd1, 16'h0000, 4'h0, 6'h3f);
        step(1, 2'd0, 16'h03f0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd3, 16'd0, 4'h0, 6'h00);
        step(1, 2'd2, 16'h0001, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        step(0, 2'd0, 16'd0, 4'h0, 6'h00);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [1:0] a;
            logic [15:0] d;
            logic [3:0] bk;
            logic [5:0] sr;
            w  = ($urandom % 4) == 0;
            a  = 2'($urandom % 4);
            d  = 16'($urandom);
            if (a == 2'd2) d[0] = ($urandom % 8) != 0;
            bk = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            sr = (($urandom % 5) == 0) ? (6'($urandom) & 6'($urandom)) : 6'h00;
            step(w, a, d, bk, sr);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule